// File: doc/BRIEF.md
# Teletext Packet Acquisition Filter

The block sits behind a data slicer and receives teletext lines as a stream of bytes. The bytes are already aligned. Each byte comes with a strobe, a marker on the first byte of a line and the number of the video line. A mode input picks one of three capture jobs:

- Broadcast-data packets addressed to magazine 8, row 30.
- The raw content of video line 16.
- Four groups of eight header bytes, stored in a fixed reordered layout.

Accepted bytes go into a 32-slot transfer register. A host reads it through a plain address/data port.

In broadcast-data mode, a Hamming 8/4 designation code sets the packet format:

- Format 1 payload bytes are stored exactly as they arrive.
- Format 2 payload bytes are Hamming 8/4 decoded. A byte with a single-bit error is corrected. A byte with a double-bit error is dropped.

Every store pulls the active-low data-available flag low. A host read request sets it high again.

Top module: `ttx_acq_filter`

## Requirements
- R1: After reset the data-available flag `dav_n` is high and all 32 transfer slots read zero.
- R2: `mode` encodes 0 = broadcast-data (packet 8/30), 1 = line 16, 2 = header bytes, 3 = idle. In idle mode nothing is ever stored.
- R3: Byte index 0 is the byte flagged by `line_start`. In mode 0, bytes 0 and 1 are Hamming 8/4 decoded to nibbles n0 and n1. The line is accepted only if both decode without an uncorrectable error, n0 = 0 (magazine 8) and n1 = 0xF with n0[3] = 0 (row 30). Any other line stores nothing.
- R4: In mode 0, byte 2 is Hamming decoded as the designation code. Value 0 or 1 selects format 1. Value 2 or 3 selects format 2. Any other value, or an uncorrectable code, stores nothing for that line.
- R5: In format 1, payload bytes at index 3 to 34 are written unchanged into slots 0 to 31 (slot = index - 3).
- R6: In format 2, each payload byte is Hamming 8/4 decoded. The slot receives {4'h0, nibble}. A single-bit error in any of the eight bit positions is corrected before storing.
- R7: In format 2, a payload byte with a double-bit error is not written: its slot keeps its old value and `dav_n` is not pulled low by it.
- R8: In mode 1, only lines with `line_num` = 16 are captured. Bytes at index 0 to 31 go unchanged to slot = index. Every other line number stores nothing.
- R9: In mode 2, a line is accepted when bytes 0 and 1 decode to row 0 (n0[3] = 0, n1 = 0), for any magazine. Header byte number b = index + 4, for b from 14 to 45, is stored in slot {~t[4:3], t[2:0]} with t = b - 14. This places bytes 38-45 in slots 0-7, 30-37 in 8-15, 22-29 in 16-23 and 14-21 in 24-31.
- R10: `dav_n` goes low on the clock edge that stores a byte. It returns high on the edge where `rd_en` is high and no store happens. A store wins when both occur together.
- R11: Hamming 8/4 bit layout (bit 1 = LSB): data bits D1-D4 at positions 2, 4, 6, 8. Protection bits are:
  - position 1 = not(D1^D3^D4)
  - position 3 = not(D1^D2^D4)
  - position 5 = not(D1^D2^D3)
  - position 7 is chosen so that the whole byte has odd parity.
- R12: `rd_data` shows slot `rd_addr` combinationally and reflects a store from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Capture mode select |
| byte_vld | input | 1 | Byte strobe |
| line_start | input | 1 | Marks byte index 0 of a line |
| line_num | input | 9 | Video line number of the current line |
| byte_in | input | 8 | Sliced line byte |
| rd_en | input | 1 | Host read request, clears the flag |
| rd_addr | input | 5 | Transfer slot to read |
| rd_data | output | 8 | Content of the addressed slot |
| dav_n | output | 1 | Active-low data-available flag |

## Verification
The bench targets single-bit errors placed on a protection bit and on a data bit. A decoder with a wrong syndrome map would store a flipped nibble. It also sends a double-bit error. A design that tried to correct it would overwrite a slot that must keep its old value, or pull the flag low with nothing valid stored. Rows 28 and 30, a wrong magazine, a bad designation code and line 15 next to line 16 check that near-miss lines leave both the slots and the flag untouched. A full header line checks the group-reversed slot layout, which catches a mapping that keeps arrival order or reverses bytes inside a group.

// File: rtl/ttx_acq_filter.sv
module ttx_acq_filter #(
  parameter int SLOTS = 32,
  parameter int IDXW  = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               mode,
  input  logic                     byte_vld,
  input  logic                     line_start,
  input  logic [8:0]               line_num,
  input  logic [7:0]               byte_in,
  input  logic                     rd_en,
  input  logic [$clog2(SLOTS)-1:0] rd_addr,
  output logic [7:0]               rd_data,
  output logic                     dav_n
);
  localparam int AW       = $clog2(SLOTS);
  localparam int PKT_FIRST = 3;
  localparam int HDR_FIRST = 10;
  localparam logic [IDXW-1:0] IDX_MAX = '1;

  localparam logic [1:0] M_BDS = 2'd0, M_L16 = 2'd1, M_HDR = 2'd2;
  localparam logic [1:0] H_OK = 2'd0, H_FIX = 2'd1, H_BAD = 2'd2;

  function automatic logic [5:0] ham84(input logic [7:0] b);
    logic s1, s2, s3, sp;
    logic [2:0] syn;
    logic [3:0] d;
    s1  = ~(b[0] ^ b[1] ^ b[5] ^ b[7]);
    s2  = ~(b[1] ^ b[2] ^ b[3] ^ b[7]);
    s3  = ~(b[1] ^ b[3] ^ b[4] ^ b[5]);
    sp  = ~(^b);
    syn = {s3, s2, s1};
    d   = {b[7], b[5], b[3], b[1]};
    if (!sp && syn == 3'd0) return {H_OK, d};
    if (!sp) return {H_BAD, d};
    d[0] = d[0] ^ (syn == 3'd7);
    d[1] = d[1] ^ (syn == 3'd6);
    d[2] = d[2] ^ (syn == 3'd5);
    d[3] = d[3] ^ (syn == 3'd3);
    return {H_FIX, d};
  endfunction

  logic [7:0]      mem [SLOTS];
  logic [IDXW-1:0] cnt, cur, off_pkt, off_hdr;
  logic [3:0]      n0;
  logic            n0_ok, acc, fmt2;
  logic [5:0]      h;
  logic            wr;
  logic [AW-1:0]   wslot;
  logic [7:0]      wdata;

  assign cur     = line_start ? '0 : cnt;
  assign h       = ham84(byte_in);
  assign off_pkt = cur - IDXW'(PKT_FIRST);
  assign off_hdr = cur - IDXW'(HDR_FIRST);
  assign rd_data = mem[rd_addr];

  always_comb begin
    wr    = 1'b0;
    wslot = '0;
    wdata = byte_in;
    case (mode)
      M_BDS: begin
        wslot = off_pkt[AW-1:0];
        if (fmt2) wdata = {4'h0, h[3:0]};
        wr = byte_vld && acc && cur >= IDXW'(PKT_FIRST) && cur < IDXW'(PKT_FIRST + SLOTS)
             && !(fmt2 && h[5:4] == H_BAD);
      end
      M_L16: begin
        wslot = cur[AW-1:0];
        wr    = byte_vld && line_num == 9'd16 && cur < IDXW'(SLOTS);
      end
      M_HDR: begin
        wslot = {~off_hdr[AW-1:AW-2], off_hdr[AW-3:0]};
        wr    = byte_vld && acc && cur >= IDXW'(HDR_FIRST) && cur < IDXW'(HDR_FIRST + SLOTS);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      n0    <= '0;
      n0_ok <= 1'b0;
      acc   <= 1'b0;
      fmt2  <= 1'b0;
      dav_n <= 1'b1;
      for (int i = 0; i < SLOTS; i++) mem[i] <= '0;
    end else begin
      if (byte_vld) begin
        if (cur != IDX_MAX) cnt <= cur + 1'b1;
        else cnt <= cur;
        case (cur)
          IDXW'(0): begin
            n0    <= h[3:0];
            n0_ok <= h[5:4] != H_BAD;
            acc   <= 1'b0;
          end
          IDXW'(1): acc <= n0_ok && h[5:4] != H_BAD &&
                           ((mode == M_BDS && n0 == 4'h0 && h[3:0] == 4'hF) ||
                            (mode == M_HDR && !n0[3] && h[3:0] == 4'h0));
          IDXW'(2): if (mode == M_BDS) begin
            acc  <= acc && h[5:4] != H_BAD && h[3:2] == 2'b00;
            fmt2 <= h[1];
          end
          default: ;
        endcase
      end
      if (wr) mem[wslot] <= wdata;
      if (wr) dav_n <= 1'b0;
      else if (rd_en) dav_n <= 1'b1;
    end
  end

  AST_IDLE_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'd3 |-> !wr);  // R2
  AST_L16_LINE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && mode == M_L16) |-> line_num == 9'd16);  // R8
  AST_F2_NIBBLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && mode == M_BDS && fmt2) |-> wdata[7:4] == 4'h0);  // R6
  AST_FLAG_FALLS_ON_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dav_n) |-> $past(wr));  // R10
  AST_FLAG_RISES_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dav_n) |-> $past(rd_en));  // R10
endmodule

// File: tb/sim_ttx_acq_filter.sv
`timescale 1ns/1ps
module sim_ttx_acq_filter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'd3;
  logic       byte_vld = 1'b0, line_start = 1'b0, rd_en = 1'b0;
  logic [8:0] line_num = '0;
  logic [7:0] byte_in = '0;
  logic [4:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       dav_n;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] lb [0:63];
  logic [7:0] exp_mem [0:31];

  always #5 clk = ~clk;

  ttx_acq_filter u0 (.clk(clk), .rst_n(rst_n), .mode(mode), .byte_vld(byte_vld),
    .line_start(line_start), .line_num(line_num), .byte_in(byte_in), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .dav_n(dav_n));

  function automatic logic [7:0] enc(input logic [3:0] n);
    logic [7:0] b;
    b[1] = n[0]; b[3] = n[1]; b[5] = n[2]; b[7] = n[3];
    b[0] = ~(n[0] ^ n[2] ^ n[3]);
    b[2] = ~(n[0] ^ n[1] ^ n[3]);
    b[4] = ~(n[0] ^ n[1] ^ n[2]);
    b[6] = ~(b[0] ^ b[1] ^ b[2] ^ b[3] ^ b[4] ^ b[5] ^ b[7]);
    return b;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_line(input int ln, input int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      byte_vld = 1'b1; line_start = (i == 0); line_num = 9'(ln); byte_in = lb[i];
    end
    @(negedge clk);
    byte_vld = 1'b0; line_start = 1'b0;
  endtask

  task automatic check_slots(input string req);
    int bad = 0;
    for (int s = 0; s < 32; s++) begin
      rd_addr = 5'(s); #1;
      if (rd_data !== exp_mem[s]) begin
        if (bad == 0) $display("FAIL %s slot %0d actual=%h expected=%h", req, s, rd_data, exp_mem[s]);
        bad++;
      end
    end
    checks++;
    if (bad != 0) errors++;
  endtask

  task automatic host_read;
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic t_reset;
    for (int s = 0; s < 32; s++) exp_mem[s] = 8'h00;
    chk("R1 dav_n after reset", {7'b0, dav_n}, 8'h01);
    check_slots("R1 slots after reset");
  endtask

  task automatic t_fmt1;
    mode = 2'd0;
    lb[0] = enc(4'h0); lb[1] = enc(4'hF); lb[2] = enc(4'h1);
    for (int i = 0; i < 32; i++) begin lb[i+3] = 8'(i*7+1); exp_mem[i] = 8'(i*7+1); end
    send_line(20, 35);
    check_slots("R5 R3 format1 raw store");
    chk("R10 dav_n low after store", {7'b0, dav_n}, 8'h00);
    rd_addr = 5'd4; #1;
    chk("R12 read port", rd_data, 8'd29);
  endtask

  task automatic t_read_clear;
    host_read();
    chk("R10 dav_n high after read", {7'b0, dav_n}, 8'h01);
  endtask

  task automatic t_fmt2;
    mode = 2'd0;
    lb[0] = enc(4'h0); lb[1] = enc(4'hF); lb[2] = enc(4'h2);
    for (int i = 0; i < 32; i++) begin lb[i+3] = enc(4'(i)); exp_mem[i] = {4'h0, 4'(i)}; end
    lb[8]  = lb[8]  ^ 8'h01;
    lb[12] = lb[12] ^ 8'h80;
    lb[17] = lb[17] ^ 8'h02;
    lb[15] = lb[15] ^ 8'h03;
    exp_mem[12] = 8'd85;
    send_line(21, 35);
    check_slots("R6 R7 R11 format2 decode and correction");
    rd_addr = 5'd9; #1;
    chk("R6 data bit error corrected", rd_data, 8'h09);
    rd_addr = 5'd12; #1;
    chk("R7 double error slot kept", rd_data, 8'd85);
    chk("R10 dav_n low after format2 store", {7'b0, dav_n}, 8'h00);
    host_read();
  endtask

  task automatic t_reject;
    mode = 2'd0;
    for (int i = 3; i < 40; i++) lb[i] = 8'hA5;
    lb[0] = enc(4'h0); lb[1] = enc(4'hE); lb[2] = enc(4'h1);
    send_line(22, 35);
    lb[0] = enc(4'h3); lb[1] = enc(4'hF);
    send_line(22, 35);
    lb[0] = enc(4'h0); lb[1] = enc(4'hF); lb[2] = enc(4'h5);
    send_line(22, 35);
    lb[2] = enc(4'h1) ^ 8'h03;
    send_line(22, 35);
    check_slots("R3 R4 rejected lines leave slots");
    chk("R3 R4 dav_n stays high on rejects", {7'b0, dav_n}, 8'h01);
  endtask

  task automatic t_all_bad;
    mode = 2'd0;
    lb[0] = enc(4'h0); lb[1] = enc(4'hF); lb[2] = enc(4'h3);
    for (int i = 0; i < 32; i++) lb[i+3] = enc(4'h6) ^ 8'h0C;
    send_line(23, 35);
    check_slots("R7 uncorrectable bytes not written");
    chk("R7 dav_n high with no valid byte", {7'b0, dav_n}, 8'h01);
  endtask

  task automatic t_line16;
    mode = 2'd1;
    for (int i = 0; i < 32; i++) lb[i] = 8'(8'hC0 ^ i);
    send_line(15, 32);
    chk("R8 line 15 ignored", {7'b0, dav_n}, 8'h01);
    check_slots("R8 line 15 leaves slots");
    send_line(16, 32);
    for (int i = 0; i < 32; i++) exp_mem[i] = 8'(8'hC0 ^ i);
    check_slots("R8 line 16 captured raw");
    chk("R8 dav_n low after line 16", {7'b0, dav_n}, 8'h00);
    host_read();
  endtask

  task automatic t_header;
    mode = 2'd2;
    lb[0] = enc(4'h3); lb[1] = enc(4'h0);
    for (int i = 2; i < 42; i++) lb[i] = 8'(i + 4);
    send_line(30, 42);
    for (int s = 0; s < 32; s++) begin
      logic [4:0] t;
      t = {~5'(s) >> 3, 3'(s)};
      exp_mem[s] = 8'(t + 14);
    end
    check_slots("R9 header group order");
    rd_addr = 5'd0; #1;
    chk("R9 slot 0 holds byte 38", rd_data, 8'd38);
    rd_addr = 5'd31; #1;
    chk("R9 slot 31 holds byte 21", rd_data, 8'd21);
    host_read();
    lb[1] = enc(4'h1);
    for (int i = 2; i < 42; i++) lb[i] = 8'h5A;
    send_line(31, 42);
    chk("R9 non-zero row ignored", {7'b0, dav_n}, 8'h01);
  endtask

  task automatic t_idle;
    mode = 2'd3;
    for (int i = 0; i < 42; i++) lb[i] = 8'h77;
    lb[0] = enc(4'h0); lb[1] = enc(4'hF); lb[2] = enc(4'h1);
    send_line(16, 42);
    check_slots("R2 idle mode stores nothing");
    chk("R2 idle dav_n high", {7'b0, dav_n}, 8'h01);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fmt1();
    t_read_clear();
    t_fmt2();
    t_reject();
    t_all_bad();
    t_line16();
    t_header();
    t_idle();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule